// File: doc/BRIEF.md
# Normalized Min-Sum Check Node Unit

This block performs the check-node half of one message-passing iteration for a single parity row of a quasi-cyclic low-density parity-check decoder. It takes every bit-to-check log-likelihood ratio of the row in one beat. For each edge it returns an extrinsic check-to-bit message. The sign of that message is the product of the signs on all the other edges of the row. Its magnitude is the smallest magnitude among those other edges, scaled down by a normalization factor of 4/3. The default row degree is 32: the row crosses sixteen circulants, and each circulant row holds two ones.

Each output must exclude its own input, so the unit finds three things in a single scan of the row: the smallest magnitude, the second smallest magnitude, and the lane that holds the smallest. The lane that holds the smallest receives the second smallest; every other lane receives the smallest. The scaling is done by a shift and a subtract. The data passes through two registered stages. The first holds the result of the search and the overall sign; the second holds the finished messages.

Each stage has its own occupancy state machine with two states, `STG_EMPTY` and `STG_FULL`, and three transitions:
- **fill**: `STG_EMPTY` to `STG_FULL`, when a beat loads into an empty stage.
- **drain**: `STG_FULL` to `STG_EMPTY`, when the beat leaves and nothing replaces it.
- **refill or hold**: `STG_FULL` stays `STG_FULL`, when a beat leaves and another arrives, or when the stage is stalled.

A valid/ready handshake on each side lets a downstream stall push back to the input without losing data.

Top module: `nms_check_unit`

## Requirements
- R1: Out of reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Lane i of `in_llr` is the 6-bit two's complement field at bits [6i+5:6i]. The code -32 is treated as -31, that is negative with magnitude 31, before any magnitude is compared.
- R3: The magnitude before scaling on lane i is the minimum absolute value over all lanes other than i.
- R4: When one lane holds the strictly smallest magnitude, that lane receives the second smallest. When the smallest value is shared by two or more lanes, every lane receives that smallest value.
- R5: The sign on output lane i is negative exactly when an odd number of the other lanes carry a negative input. A negative input is one whose bit 5 is set; zero counts as positive.
- R6: A magnitude m before scaling is output as m - floor(m/4). Lane i of `out_msg` sits at bits [6i+5:6i] as 6-bit two's complement, and its magnitude never exceeds 24.
- R7: A beat accepted at a clock edge presents `out_valid` after the second following edge. With `out_ready` held high, one beat is accepted every cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_msg` holds its value. `in_ready` drops only when both stages are full and the output is stalled. Every accepted beat leaves in order, exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A row of input messages is offered |
| in_ready | output | 1 | The unit can accept the offered row |
| in_llr | input | DEGREE*LLR_W | Bit-to-check messages, lane i at [LLR_W*i +: LLR_W] |
| out_valid | output | 1 | A row of output messages is presented |
| out_ready | input | 1 | The consumer takes the presented row |
| out_msg | output | DEGREE*LLR_W | Check-to-bit messages, lane i at [LLR_W*i +: LLR_W] |

## Verification
The bench builds the unit with its defaults, DEGREE = 32 and LLR_W = 6. At that size every magnitude from 0 to 31 and the saturating code -32 can appear, and the search for the smallest and second smallest magnitudes covers the full row degree. Random rows combined with a random `out_ready` exercise stalls that fill both stages. Directed rows place a unique minimum at the first and the last lane, create ties, and use all-negative and all-zero rows, so the exclude-self choice, the sign parity and the saturation are each reached on their own.

// File: rtl/nms_pkg.sv
package nms_pkg;
    typedef enum logic {
        STG_EMPTY = 1'b0,
        STG_FULL  = 1'b1
    } stage_state_t;
endpackage

// File: rtl/nms_stage_ctl.sv
module nms_stage_ctl
    import nms_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic drain,
    output logic full
);
    stage_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= STG_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STG_EMPTY: if (load)           state_d = STG_FULL;   // fill
            STG_FULL:  if (drain && !load) state_d = STG_EMPTY;  // drain
            default:                       state_d = STG_EMPTY;
        endcase
    end

    always_comb full = (state_q == STG_FULL);

    // R8: a full stage that does not drain must not be loaded again
    assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !drain) |-> !load);
endmodule

// File: rtl/nms_mag_sign.sv
module nms_mag_sign #(
    parameter int DEGREE = 32,
    parameter int LLR_W  = 6,
    localparam int MAG_W = LLR_W - 1
) (
    input  logic [DEGREE*LLR_W-1:0] in_llr,
    output logic [DEGREE*MAG_W-1:0] mags,
    output logic [DEGREE-1:0]       signs
);
    localparam logic [LLR_W-1:0] MOST_NEG = {1'b1, {(LLR_W-1){1'b0}}};

    for (genvar g = 0; g < DEGREE; g++) begin : g_lane
        logic [LLR_W-1:0] raw, negated;
        always_comb begin
            raw      = in_llr[g*LLR_W +: LLR_W];
            negated  = ~raw + 1'b1;
            signs[g] = raw[LLR_W-1];
            if (!raw[LLR_W-1])
                mags[g*MAG_W +: MAG_W] = raw[MAG_W-1:0];
            else if (raw == MOST_NEG)
                mags[g*MAG_W +: MAG_W] = '1;          // R2 saturation
            else
                mags[g*MAG_W +: MAG_W] = negated[MAG_W-1:0];
        end
    end
endmodule

// File: rtl/nms_min_search.sv
module nms_min_search #(
    parameter int DEGREE = 32,
    parameter int MAG_W  = 5,
    localparam int IDX_W = $clog2(DEGREE)
) (
    input  logic [DEGREE*MAG_W-1:0] mags,
    input  logic [DEGREE-1:0]       signs,
    output logic [MAG_W-1:0]        min1,
    output logic [MAG_W-1:0]        min2,
    output logic [IDX_W-1:0]        min1_idx,
    output logic                    sign_all
);
    always_comb begin
        logic [MAG_W-1:0] cur;
        min1     = '1;
        min2     = '1;
        min1_idx = '0;
        sign_all = 1'b0;
        for (int i = 0; i < DEGREE; i++) begin
            cur = mags[i*MAG_W +: MAG_W];
            if (cur < min1) begin
                min2     = min1;
                min1     = cur;
                min1_idx = IDX_W'(i);
            end else if (cur < min2) begin
                min2 = cur;
            end
            sign_all = sign_all ^ signs[i];
        end
    end
endmodule

// File: rtl/nms_scale_out.sv
module nms_scale_out #(
    parameter int DEGREE = 32,
    parameter int LLR_W  = 6,
    localparam int MAG_W = LLR_W - 1,
    localparam int IDX_W = $clog2(DEGREE)
) (
    input  logic [MAG_W-1:0]        min1,
    input  logic [MAG_W-1:0]        min2,
    input  logic [IDX_W-1:0]        min1_idx,
    input  logic                    sign_all,
    input  logic [DEGREE-1:0]       signs,
    output logic [DEGREE*LLR_W-1:0] msgs
);
    logic [MAG_W-1:0] scaled1, scaled2;

    always_comb begin
        scaled1 = min1 - (min1 >> 2);
        scaled2 = min2 - (min2 >> 2);
    end

    for (genvar g = 0; g < DEGREE; g++) begin : g_lane
        logic [LLR_W-1:0] pos;
        logic             neg;
        always_comb begin
            pos = {1'b0, (min1_idx == IDX_W'(g)) ? scaled2 : scaled1};
            neg = sign_all ^ signs[g];
            msgs[g*LLR_W +: LLR_W] = neg ? (~pos + 1'b1) : pos;
        end
    end
endmodule

// File: rtl/nms_check_unit.sv
module nms_check_unit #(
    parameter int DEGREE = 32,
    parameter int LLR_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [DEGREE*LLR_W-1:0] in_llr,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [DEGREE*LLR_W-1:0] out_msg
);
    localparam int MAG_W   = LLR_W - 1;
    localparam int IDX_W   = $clog2(DEGREE);
    localparam int MAX_MAG = (1 << MAG_W) - 1;
    localparam logic [LLR_W-1:0] MAX_OUT = LLR_W'(MAX_MAG - (MAX_MAG >> 2));

    logic [DEGREE*MAG_W-1:0] mags;
    logic [DEGREE-1:0]       signs;
    logic [MAG_W-1:0]        f_min1, f_min2;
    logic [IDX_W-1:0]        f_idx;
    logic                    f_sall;

    logic [MAG_W-1:0]        s1_min1, s1_min2;
    logic [IDX_W-1:0]        s1_idx;
    logic                    s1_sall;
    logic [DEGREE-1:0]       s1_signs;
    logic [DEGREE*LLR_W-1:0] f_msgs;

    logic s1_full, s2_full, s1_load, s2_load, s2_ready, out_fire;

    always_comb begin
        s2_ready  = !s2_full || out_ready;
        in_ready  = !s1_full || s2_ready;
        s1_load   = in_valid && in_ready;
        s2_load   = s1_full && s2_ready;
        out_fire  = s2_full && out_ready;
        out_valid = s2_full;
    end

    nms_stage_ctl i_ctl_search (
        .clk(clk), .rst_n(rst_n), .load(s1_load), .drain(s2_load), .full(s1_full));
    nms_stage_ctl i_ctl_output (
        .clk(clk), .rst_n(rst_n), .load(s2_load), .drain(out_fire), .full(s2_full));

    nms_mag_sign #(.DEGREE(DEGREE), .LLR_W(LLR_W)) i_mag (
        .in_llr(in_llr), .mags(mags), .signs(signs));

    nms_min_search #(.DEGREE(DEGREE), .MAG_W(MAG_W)) i_search (
        .mags(mags), .signs(signs), .min1(f_min1), .min2(f_min2),
        .min1_idx(f_idx), .sign_all(f_sall));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_min1  <= '1;
            s1_min2  <= '1;
            s1_idx   <= '0;
            s1_sall  <= 1'b0;
            s1_signs <= '0;
        end else if (s1_load) begin
            s1_min1  <= f_min1;
            s1_min2  <= f_min2;
            s1_idx   <= f_idx;
            s1_sall  <= f_sall;
            s1_signs <= signs;
        end
    end

    nms_scale_out #(.DEGREE(DEGREE), .LLR_W(LLR_W)) i_scale (
        .min1(s1_min1), .min2(s1_min2), .min1_idx(s1_idx), .sign_all(s1_sall),
        .signs(s1_signs), .msgs(f_msgs));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       out_msg <= '0;
        else if (s2_load) out_msg <= f_msgs;
    end

    // R4: the registered search result keeps the two minima in order
    assert_min_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s1_full |-> (s1_min1 <= s1_min2));

    // R7: an accepted beat occupies the search stage on the next cycle
    assert_accept_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> s1_full);

    // R7: a search result that may advance is presented on the next cycle
    assert_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_full && (!out_valid || out_ready)) |=> out_valid);

    // R8: a stalled output keeps its value
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_msg)));

    // R8: back-pressure reaches the input only through a stalled output
    assert_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid && !out_ready));

    for (genvar g = 0; g < DEGREE; g++) begin : g_chk
        logic [LLR_W-1:0] lane;
        always_comb lane = out_msg[g*LLR_W +: LLR_W];
        // R6: no presented message exceeds the scaled magnitude bound
        assert_out_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (lane[LLR_W-1] ? ((~lane + 1'b1) <= MAX_OUT) : (lane <= MAX_OUT)));
    end
endmodule

// File: tb/test_nms_check_unit.sv
module test_nms_check_unit;
    localparam int CLK_PERIOD = 10;
    localparam int DEGREE     = 32;
    localparam int LLR_W      = 6;
    localparam int BUS_W      = DEGREE * LLR_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [BUS_W-1:0] in_llr = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [BUS_W-1:0] out_msg;

    int n_checks = 0;
    int n_fail   = 0;
    logic [BUS_W-1:0] expq[$];
    logic seen_ov, seen_ir, seen_acc;

    nms_check_unit #(.DEGREE(DEGREE), .LLR_W(LLR_W)) i_nms_check_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_llr(in_llr), .out_valid(out_valid), .out_ready(out_ready), .out_msg(out_msg));

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [BUS_W-1:0] model(input logic [BUS_W-1:0] v);
        int mag[DEGREE];
        bit sg[DEGREE];
        logic [BUS_W-1:0] r;
        for (int i = 0; i < DEGREE; i++) begin
            int x;
            x = int'($signed(v[i*LLR_W +: LLR_W]));
            if (x < -31) x = -31;
            sg[i]  = (x < 0);
            mag[i] = (x < 0) ? -x : x;
        end
        for (int i = 0; i < DEGREE; i++) begin
            int best, sc, val;
            bit s;
            best = 1000;
            s = 1'b0;
            for (int j = 0; j < DEGREE; j++) begin
                if (j != i) begin
                    if (mag[j] < best) best = mag[j];
                    s ^= sg[j];
                end
            end
            sc  = best - best / 4;
            val = s ? -sc : sc;
            r[i*LLR_W +: LLR_W] = val[LLR_W-1:0];
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_row(input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp,
                               input string req);
        int bad;
        bad = -1;
        for (int i = DEGREE - 1; i >= 0; i--)
            if (act[i*LLR_W +: LLR_W] !== exp[i*LLR_W +: LLR_W]) bad = i;
        if (bad < 0) check(1'b1, req, "row", 0, 0);
        else check(1'b0, req, $sformatf("lane %0d", bad),
                   longint'($signed(act[bad*LLR_W +: LLR_W])),
                   longint'($signed(exp[bad*LLR_W +: LLR_W])));
    endtask

    // Called just after a falling edge with inputs set; samples before the rising edge.
    task automatic step();
        #(CLK_PERIOD/2 - 1);
        seen_ov  = out_valid;
        seen_ir  = in_ready;
        seen_acc = in_valid && in_ready;
        if (out_valid && out_ready) begin
            if (expq.size() == 0) check(1'b0, "R8", "unexpected output", 1, 0);
            else compare_row(out_msg, expq.pop_front(), "R3 R4 R5 R6");
        end
        if (seen_acc) expq.push_back(model(in_llr));
        @(negedge clk);
    endtask

    task automatic send(input logic [BUS_W-1:0] v);
        in_valid = 1'b1;
        in_llr   = v;
        do step(); while (!seen_acc);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        out_ready = 1'b1;
        for (int k = 0; k < 20 && (expq.size() != 0); k++) step();
        check(expq.size() == 0, "R8", "rows left undelivered", expq.size(), 0);
    endtask

    function automatic logic [BUS_W-1:0] fill(input int value);
        logic [BUS_W-1:0] r;
        for (int i = 0; i < DEGREE; i++) r[i*LLR_W +: LLR_W] = value[LLR_W-1:0];
        return r;
    endfunction

    function automatic logic [BUS_W-1:0] rand_row(input int mode);
        logic [BUS_W-1:0] r;
        for (int i = 0; i < DEGREE; i++) begin
            int k, x;
            k = int'($urandom % 8);
            if (mode == 1)      x = 8 + int'($urandom % 24);
            else if (k == 0)    x = int'($urandom % 4);
            else if (k == 1)    x = 32;
            else                x = int'($urandom % 64);
            r[i*LLR_W +: LLR_W] = x[LLR_W-1:0];
        end
        if (mode == 1) begin
            int p, y;
            p = int'($urandom % DEGREE);
            y = int'($urandom % 6);
            if ($urandom % 2 == 1) y = -y;
            r[p*LLR_W +: LLR_W] = y[LLR_W-1:0];
        end
        return r;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [BUS_W-1:0] v, held;
        int accepted;
        void'($urandom(32'd5171));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        check(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: latency of two edges
        out_ready = 1'b1;
        in_valid = 1'b1;
        in_llr = rand_row(0);
        step();
        check(seen_acc == 1'b1, "R7", "first beat accepted", seen_acc, 1);
        in_valid = 1'b0;
        step();
        check(seen_ov == 1'b0, "R7", "out_valid one cycle after accept", seen_ov, 0);
        step();
        check(seen_ov == 1'b1, "R7", "out_valid two cycles after accept", seen_ov, 1);

        // R7: full throughput with out_ready high
        in_valid = 1'b1;
        for (int k = 0; k < 6; k++) begin
            in_llr = rand_row(1);
            step();
            check(seen_ir == 1'b1, "R7", "in_ready at full rate", seen_ir, 1);
        end
        in_valid = 1'b0;
        drain();

        // R2: all -32 -> every lane -24 (101000)
        send(fill(-32));
        step(); step();
        check(out_msg[LLR_W-1:0] == 6'b101000, "R2", "lane 0 of all -32 row",
              longint'($signed(out_msg[LLR_W-1:0])), -24);
        check(out_msg[BUS_W-1 -: LLR_W] == 6'b101000, "R2", "lane 31 of all -32 row",
              longint'($signed(out_msg[BUS_W-1 -: LLR_W])), -24);
        drain();

        // R4: unique minimum in lane 0: lane 0 gets 20-5=15, others -3 -> 3-0=3
        v = fill(20);
        v[LLR_W-1:0] = 6'b111101;
        send(v);
        step(); step();
        check(out_msg[LLR_W-1:0] == 6'd15, "R4", "lane 0 takes second minimum",
              out_msg[LLR_W-1:0], 15);
        check(out_msg[LLR_W +: LLR_W] == 6'b111101, "R5", "other lane sign and value",
              longint'($signed(out_msg[LLR_W +: LLR_W])), -3);
        drain();

        // R4: tie at minimum between lanes 31 and 5: all lanes get 4 -> 3
        v = fill(12);
        v[BUS_W-1 -: LLR_W] = 6'd4;
        v[5*LLR_W +: LLR_W] = 6'd4;
        send(v);
        step(); step();
        check(out_msg[BUS_W-1 -: LLR_W] == 6'd3, "R4", "tied lane 31",
              out_msg[BUS_W-1 -: LLR_W], 3);
        drain();

        // R5 / R6: directed rows through the model
        send(fill(0));
        send(fill(31));
        send(fill(1));
        v = fill(-7);
        v[9*LLR_W +: LLR_W] = 6'd0;
        send(v);
        drain();

        // R8: stall fills both stages, then in_ready drops
        out_ready = 1'b0;
        in_valid = 1'b1;
        accepted = 0;
        for (int k = 0; k < 4; k++) begin
            if (k == 0 || seen_acc) in_llr = rand_row(1);
            step();
            if (seen_acc) accepted++;
        end
        check(accepted == 2, "R8", "beats accepted while stalled", accepted, 2);
        check(seen_ir == 1'b0, "R8", "in_ready low with both stages full", seen_ir, 0);
        held = out_msg;
        step(); step();
        check(out_msg == held, "R8", "output held under stall", 0, 0);
        in_valid = 1'b0;
        drain();

        // Random traffic with random back-pressure
        for (int n = 0; n < 400; n++) begin
            out_ready = ($urandom % 4) != 0;
            if ($urandom % 5 == 0) step();
            in_valid = 1'b1;
            in_llr = rand_row(int'($urandom % 2));
            do begin
                step();
                out_ready = ($urandom % 4) != 0;
            end while (!seen_acc);
            in_valid = 1'b0;
        end
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule